// File: doc/BRIEF.md
# Link-Aligned Epoch Counter Synchronizer

Each chip in a multi-chip system runs a free-running 8-bit epoch counter. This block keeps the local counter in step with the counter of one linked neighbour. It exchanges counter values over a word-wide transmit/receive interface, and a role input chooses which side leads. The leading side, called the parent, keeps counting freely and sends its counter value at a fixed cadence. The following side, called the child, first measures the link. It sends its own counter value as a probe, the neighbour sends the same word back as an echo, and the child subtracts the returned word from its current count to get one round-trip sample. It takes a power-of-two number of these samples and averages them to find the one-way delay.

After the measurement, the child adds the averaged delay to each counter value the parent sends. It compares this sum with its own count using modulo-256 arithmetic and reads the result as a signed misalignment. It then corrects by one step only. If it is ahead, it holds its count for one cycle. If it is behind, it skips one count. Repeated updates walk the two counters together until only link jitter remains. The aligned flag rises once a programmable number of consecutive updates have all stayed within the tolerance.

The controller is a single state machine with five states. ST_IDLE waits for `start`. ST_IDLE goes to ST_LEAD on start with the parent role, or to ST_PROBE on start with the child role. ST_PROBE goes to ST_WAIT once the probe has left. ST_WAIT goes back to ST_PROBE when a non-final echo arrives, or to ST_TRACK when the final echo arrives. ST_LEAD and ST_TRACK are terminal until reset. Echoes are returned in every state.

Top module: `epoch_align`

## Requirements
- R1: `epoch` is 0 in reset. After reset it advances by exactly 1 per cycle and wraps from 255 to 0, so it shows the same value again 256 cycles later. It is never adjusted while the block waits for `start`.
- R2: A received word of kind PROBE (code 0) in cycle k is sent back in cycle k+1 as kind ECHO (code 1) with the identical word, in either role. An echo takes priority over any other transmission.
- R3: In the child role (`role_child`=1), `start` launches exactly TRIALS probes, one at a time, each carrying `epoch` of the cycle it leaves in. Each returned echo yields the sample (`epoch` − returned word) mod 256.
- R4: After the last echo, `tracking` rises and `avg_delay` holds ((sum of the samples) >> log2(TRIALS)) >> 1, which is the one-way delay.
- R5: While `tracking`, a received word of kind SYNC (code 2) produces, on the next cycle, `misalign` = (`epoch` − word − `avg_delay`) mod 256 read as a signed value in −128..+127.
- R6: On that update, the counter steps by 0 when the misalignment is positive, by 2 when it is negative, and by 1 when it is zero. Between updates the counter steps by 1.
- R7: `aligned` is high exactly when the last RUN_LEN updates all had |misalignment| ≤ `tol`. One update outside the tolerance clears it.
- R8: In the parent role, a SYNC carrying the `epoch` of its own cycle is sent every SYNC_PERIOD cycles. The parent counter never deviates from +1 per cycle, and a received SYNC has no effect on it.
- R9: A child facing a fixed link delay, echo jitter and a parent clock that is slower by one count every few tens of cycles reaches `aligned` with |`misalign`| ≤ `tol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin operation in the selected role (taken in ST_IDLE only) |
| role_child | input | 1 | 1 = child (measure then follow), 0 = parent (lead) |
| tol | input | 8 | Largest magnitude of misalignment counted as aligned |
| rx_valid | input | 1 | Received word present this cycle |
| rx_kind | input | 2 | Received word kind: 0 probe, 1 echo, 2 sync |
| rx_word | input | 8 | Received counter value |
| tx_valid | output | 1 | Transmitted word present this cycle |
| tx_kind | output | 2 | Transmitted word kind, same coding as rx_kind |
| tx_word | output | 8 | Transmitted counter value |
| epoch | output | 8 | Local epoch counter |
| avg_delay | output | 8 | Averaged one-way link delay |
| misalign | output | 8 | Signed misalignment of the latest update |
| aligned | output | 1 | Alignment held for RUN_LEN consecutive updates |
| tracking | output | 1 | Child has finished measuring and is following |

## Verification
The child's main function is driven with three kinds of pattern. A constant delay with a parent ahead by a small amount forces repeated skips, which separates the behind-side correction from the ahead side. A parent offset of about 200 counts wraps to a positive signed misalignment, so it shows whether the subtraction is read as signed rather than unsigned, and it drives the hold path. Echo turnaround that alternates between one and two cycles, together with a parent that drops a count every 37 cycles, shows whether the averaging shift is right and whether the correction stays within the tolerance under steady drift. The parent role is tried with and without an incoming probe or sync, which shows that cadence, echo priority and the ignored sync are separate from the child path.

// File: rtl/epoch_sync_pkg.sv
package epoch_sync_pkg;

    // Word kinds carried on the link; encodings are visible at the ports.
    typedef enum logic [1:0] {
        WK_PROBE = 2'd0,
        WK_ECHO  = 2'd1,
        WK_SYNC  = 2'd2,
        WK_NONE  = 2'd3
    } word_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_PROBE = 3'd2,
        ST_WAIT  = 3'd3,
        ST_TRACK = 3'd4
    } sync_state_t;

endpackage

// File: rtl/epoch_counter.sv
module epoch_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          skip,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (hold)   cnt <= cnt;
        else if (skip)   cnt <= cnt + CW'(2);
        else             cnt <= cnt + CW'(1);
    end

    // R6
    hold_skip_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold && skip));

endmodule

// File: rtl/delay_meter.sv
module delay_meter #(
    parameter int CW     = 8,
    parameter int TRIALS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          take,
    input  logic [CW-1:0] now,
    input  logic [CW-1:0] back,
    output logic          last,
    output logic [CW-1:0] avg
);

    localparam int LG = $clog2(TRIALS);
    localparam int AW = CW + LG;
    localparam int TW = $clog2(TRIALS + 1);

    logic [AW-1:0] acc, acc_nx;
    logic [TW-1:0] trials;
    logic [CW-1:0] sample;

    assign sample = now - back;              // modulo round trip
    assign acc_nx = acc + AW'(sample);
    assign last   = (trials == TW'(TRIALS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc    <= '0;
            trials <= '0;
            avg    <= '0;
        end else if (take) begin
            acc    <= acc_nx;
            trials <= trials + TW'(1);
            if (last) avg <= CW'((acc_nx >> LG) >> 1);
        end
    end

    // R3
    trial_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trials <= TW'(TRIALS));

endmodule

// File: rtl/align_tracker.sv
module align_tracker #(
    parameter int CW      = 8,
    parameter int RUN_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 upd,
    input  logic [CW-1:0]        own,
    input  logic [CW-1:0]        ref_word,
    input  logic [CW-1:0]        delay,
    input  logic [CW-1:0]        tol,
    output logic                 hold,
    output logic                 skip,
    output logic signed [CW-1:0] misalign,
    output logic                 aligned
);

    localparam int RW = $clog2(RUN_LEN + 1);

    logic signed [CW-1:0] diff;
    logic [CW-1:0]        mag;
    logic                 in_tol;
    logic [RW-1:0]        streak;

    assign diff   = own - ref_word - delay;
    assign mag    = diff[CW-1] ? (~diff + CW'(1)) : diff;
    assign in_tol = (mag <= tol);
    assign hold   = upd && !diff[CW-1] && (diff != '0);
    assign skip   = upd && diff[CW-1];
    assign aligned = (streak == RW'(RUN_LEN));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            streak   <= '0;
            misalign <= '0;
        end else if (upd) begin
            misalign <= diff;
            if (!in_tol)                      streak <= '0;
            else if (streak != RW'(RUN_LEN))  streak <= streak + RW'(1);
        end
    end

    // R7
    aligned_after_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aligned) |-> $past(upd));

endmodule

// File: rtl/epoch_align.sv
module epoch_align #(
    parameter int CW          = 8,
    parameter int TRIALS      = 8,
    parameter int SYNC_PERIOD = 16,
    parameter int RUN_LEN     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 role_child,
    input  logic [CW-1:0]        tol,
    input  logic                 rx_valid,
    input  logic [1:0]           rx_kind,
    input  logic [CW-1:0]        rx_word,
    output logic                 tx_valid,
    output logic [1:0]           tx_kind,
    output logic [CW-1:0]        tx_word,
    output logic [CW-1:0]        epoch,
    output logic [CW-1:0]        avg_delay,
    output logic signed [CW-1:0] misalign,
    output logic                 aligned,
    output logic                 tracking
);
    import epoch_sync_pkg::*;

    localparam int PW = $clog2(SYNC_PERIOD + 1);

    sync_state_t   st, st_nx;
    word_kind_t    rk;
    logic          echo_pend, sync_pend;
    logic [CW-1:0] echo_word;
    logic [PW-1:0] per_cnt;
    logic          hold, skip, last, clr;
    logic          send_echo, send_sync, send_probe, echo_rx, sync_rx;

    assign rk         = word_kind_t'(rx_kind);
    assign clr        = (st == ST_IDLE) && start;
    assign send_echo  = echo_pend;
    assign send_sync  = (st == ST_LEAD) && sync_pend && !echo_pend;
    assign send_probe = (st == ST_PROBE) && !echo_pend;
    assign echo_rx    = rx_valid && (rk == WK_ECHO) && (st == ST_WAIT);
    assign sync_rx    = rx_valid && (rk == WK_SYNC) && (st == ST_TRACK);

    epoch_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hold(hold), .skip(skip), .cnt(epoch)
    );

    delay_meter #(.CW(CW), .TRIALS(TRIALS)) u_meter (
        .clk(clk), .rst_n(rst_n), .clear(clr), .take(echo_rx),
        .now(epoch), .back(rx_word), .last(last), .avg(avg_delay)
    );

    align_tracker #(.CW(CW), .RUN_LEN(RUN_LEN)) u_track (
        .clk(clk), .rst_n(rst_n), .clear(clr), .upd(sync_rx),
        .own(epoch), .ref_word(rx_word), .delay(avg_delay), .tol(tol),
        .hold(hold), .skip(skip), .misalign(misalign), .aligned(aligned)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start) st_nx = role_child ? ST_PROBE : ST_LEAD;
            ST_PROBE: if (send_probe) st_nx = ST_WAIT;
            ST_WAIT:  if (echo_rx) st_nx = last ? ST_TRACK : ST_PROBE;
            ST_LEAD:  st_nx = ST_LEAD;
            ST_TRACK: st_nx = ST_TRACK;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Echo holding and parent cadence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            echo_pend <= 1'b0;
            echo_word <= '0;
        end else if (rx_valid && rk == WK_PROBE) begin
            echo_pend <= 1'b1;
            echo_word <= rx_word;
        end else if (send_echo) begin
            echo_pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || st != ST_LEAD) begin
            per_cnt   <= '0;
            sync_pend <= 1'b0;
        end else begin
            per_cnt <= (per_cnt == PW'(SYNC_PERIOD - 1)) ? '0 : per_cnt + PW'(1);
            if (per_cnt == PW'(SYNC_PERIOD - 1)) sync_pend <= 1'b1;
            else if (send_sync)                  sync_pend <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_kind  = WK_NONE;
        tx_word  = '0;
        tracking = (st == ST_TRACK);
        if (send_echo) begin
            tx_valid = 1'b1; tx_kind = WK_ECHO;  tx_word = echo_word;
        end else if (send_sync) begin
            tx_valid = 1'b1; tx_kind = WK_SYNC;  tx_word = epoch;
        end else if (send_probe) begin
            tx_valid = 1'b1; tx_kind = WK_PROBE; tx_word = epoch;
        end
    end

    // R2
    echo_turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_kind == 2'd0) |=>
            (tx_valid && tx_kind == 2'd1 && tx_word == $past(rx_word)));

    // R1
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> (epoch == $past(epoch) + CW'(1)));

    // R8
    lead_free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LEAD) |=> (epoch == $past(epoch) + CW'(1)));

endmodule

// File: tb/epoch_align_test.sv
`timescale 1ns/1ps
module epoch_align_test;
    localparam int TRIALS = 8;
    localparam int PER    = 16;
    localparam int RUN    = 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, role_child = 1'b0;
    logic [7:0] tol = 8'd0;
    logic rx_valid = 1'b0;
    logic [1:0] rx_kind = 2'd0;
    logic [7:0] rx_word = 8'd0;
    logic tx_valid, aligned, tracking;
    logic [1:0] tx_kind;
    logic [7:0] tx_word, epoch, avg_delay;
    logic signed [7:0] misalign;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic       up_v [64];
    logic [1:0] up_k [64];
    logic [7:0] up_w [64];
    logic       dn_v [64];
    logic [1:0] dn_k [64];
    logic [7:0] dn_w [64];

    epoch_align #(.CW(8), .TRIALS(TRIALS), .SYNC_PERIOD(PER), .RUN_LEN(RUN)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .role_child(role_child), .tol(tol),
        .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_word(rx_word),
        .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_word(tx_word),
        .epoch(epoch), .avg_delay(avg_delay), .misalign(misalign),
        .aligned(aligned), .tracking(tracking)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; rx_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: reset values, per-cycle step and wrap
    task automatic test_reset_wrap();
        int e0;
        rst_n = 1'b0; rx_valid = 1'b0; start = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset epoch", epoch == 8'd0, epoch, 0);
        chk("R7 reset aligned", aligned == 1'b0, aligned, 0);
        chk("R4 reset avg_delay", avg_delay == 8'd0, avg_delay, 0);
        chk("R2 reset tx_valid", tx_valid == 1'b0, tx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first step", epoch == 8'd1, epoch, 1);
        e0 = epoch;
        repeat (256) @(negedge clk);
        chk("R1 period 256", epoch == 8'(e0), epoch, e0);
        while (epoch != 8'd255) @(negedge clk);
        @(negedge clk);
        chk("R1 wrap to zero", epoch == 8'd0, epoch, 0);
    endtask

    // R8 / R2: parent cadence, echo, ignored sync
    task automatic test_parent();
        int last_k, seen, ep;
        do_reset();
        role_child = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        last_k = -1; seen = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (tx_valid && tx_kind == 2'd2) begin
                chk("R8 sync word is epoch", tx_word == epoch, tx_word, epoch);
                if (last_k >= 0) chk("R8 sync interval", (k - last_k) == PER, k - last_k, PER);
                last_k = k; seen++;
            end
        end
        chk("R8 syncs sent", seen >= 4, seen, 4);
        rx_valid = 1'b1; rx_kind = 2'd0; rx_word = 8'h3C;
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R2 echo valid kind", tx_valid && tx_kind == 2'd1, tx_kind, 1);
        chk("R2 echo word", tx_word == 8'h3C, tx_word, 'h3C);
        ep = epoch;
        rx_valid = 1'b1; rx_kind = 2'd2; rx_word = 8'(ep + 100);
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R8 sync ignored step", epoch == 8'(ep + 1), epoch, (ep + 1) & 255);
        @(negedge clk);
        chk("R8 sync ignored next", epoch == 8'(ep + 2), epoch, (ep + 2) & 255);
        chk("R8 parent misalign untouched", misalign == 8'sd0, misalign, 0);
    endtask

    // Child: bench plays the parent over a delayed link
    task automatic run_child(input int d, input int off, input int jit, input int drift,
                             input int tol_v, input int cycles, output int first_e);
        int pc, echo_at, probe_idx, probes, sample_sum, exp_avg, streak;
        int pe_mis, pe_ep, pe_al, e, raw, stp, mag;
        bit pend_chk, avg_checked, have_first;
        logic [7:0] echo_w;
        logic bv; logic [1:0] bk; logic [7:0] bw;
        do_reset();
        role_child = 1'b1; tol = 8'(tol_v);
        for (int i = 0; i < 64; i++) begin
            up_v[i] = 1'b0; dn_v[i] = 1'b0; up_k[i] = 2'd3; dn_k[i] = 2'd3;
            up_w[i] = 8'd0; dn_w[i] = 8'd0;
        end
        pc = off; echo_at = -1; echo_w = 8'd0; probe_idx = 0; probes = 0;
        sample_sum = 0; exp_avg = 0; streak = 0; pend_chk = 0;
        avg_checked = 0; have_first = 0; first_e = 0;
        pe_mis = 0; pe_ep = 0; pe_al = 0;
        start = 1'b1;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (pend_chk) begin
                chk("R5 misalign value", int'(misalign) == pe_mis, int'(misalign), pe_mis);
                chk("R6 correction step", epoch == 8'(pe_ep), epoch, pe_ep);
                chk("R7 aligned flag", aligned == pe_al[0], aligned, pe_al);
                pend_chk = 0;
            end
            if (tracking && !avg_checked) begin
                exp_avg = ((sample_sum / TRIALS) >> 1) & 255;
                chk("R4 avg_delay", avg_delay == 8'(exp_avg), avg_delay, exp_avg);
                avg_checked = 1;
            end
            if (tx_valid && tx_kind == 2'd0) begin
                chk("R3 probe carries epoch", tx_word == epoch, tx_word, epoch);
                probes++;
            end
            up_v[k % 64] = tx_valid; up_k[k % 64] = tx_kind; up_w[k % 64] = tx_word;
            // parent side receives child words after d cycles
            if (k >= d && up_v[(k - d) % 64] && up_k[(k - d) % 64] == 2'd0) begin
                stp = (jit != 0 && (probe_idx % 2) == 1) ? 2 : 1;
                echo_at = k + stp;
                echo_w = up_w[(k - d) % 64];
                sample_sum += 2 * d + stp;
                probe_idx++;
            end
            bv = 1'b0; bk = 2'd3; bw = 8'd0;
            if (echo_at == k) begin
                bv = 1'b1; bk = 2'd1; bw = echo_w;
            end else if (probe_idx == TRIALS && echo_at < k && (k % 4) == 0) begin
                bv = 1'b1; bk = 2'd2; bw = 8'(pc);
            end
            dn_v[k % 64] = bv; dn_k[k % 64] = bk; dn_w[k % 64] = bw;
            if (k >= d) begin
                rx_valid = dn_v[(k - d) % 64];
                rx_kind  = dn_k[(k - d) % 64];
                rx_word  = dn_w[(k - d) % 64];
            end else begin
                rx_valid = 1'b0;
            end
            if (rx_valid && rx_kind == 2'd2 && tracking) begin
                raw = (int'(epoch) - int'(rx_word) - exp_avg) & 255;
                e = (raw >= 128) ? raw - 256 : raw;
                stp = (e > 0) ? 0 : ((e < 0) ? 2 : 1);
                mag = (e < 0) ? -e : e;
                if (mag <= tol_v) streak = (streak < RUN) ? streak + 1 : RUN;
                else streak = 0;
                pe_mis = e; pe_ep = (int'(epoch) + stp) & 255;
                pe_al = (streak == RUN) ? 1 : 0;
                pend_chk = 1;
                if (!have_first) begin first_e = e; have_first = 1; end
            end
            if (drift == 0 || (k % drift) != drift - 1) pc = (pc + 1) & 255;
        end
        rx_valid = 1'b0;
        chk("R3 probe count", probes == TRIALS, probes, TRIALS);
        chk("R9 aligned at end", aligned == 1'b1, aligned, 1);
        mag = (int'(misalign) < 0) ? -int'(misalign) : int'(misalign);
        chk("R9 final misalign within tol", mag <= tol_v, mag, tol_v);
    endtask

    initial begin
        int fe;
        test_reset_wrap();
        test_parent();
        // child behind: skip path, constant delay
        run_child(5, 40, 0, 0, 0, 800, fe);
        chk("R5 behind reads negative", fe < 0, fe, -1);
        // large offset wraps positive: hold path, jitter and drift
        run_child(6, 200, 1, 37, 1, 900, fe);
        chk("R5 wrapped offset reads positive", fe > 0, fe, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule